// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block gathers interrupt events from a network controller's transmit engine, receive engine, bus interface and management logic into one 32-bit status word. Each event arrives as a single-cycle pulse and sets a sticky bit. The bit stays set until the host reads the word. Some bits are not latched directly from an input. A summary bit reports whether any bus or reset-completion error bit is set. A common receive-descriptor bit and a common transmit-descriptor bit can also be set by per-queue descriptor events when priority queueing is enabled.

The transmit and receive idle indicators are levels, and the block detects their rising edges itself. A status bit is set only on a move into idle. The early-threshold event is limited to one per received packet, and a start-of-packet strobe re-arms it. A host read returns the current word and clears every bit at the same clock edge. A host-written mask decides which set bits drive the interrupt output.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, `stat_o` and `irq_o` are zero.
- R2: A pulse on `evt_i` bit k sets status bit k on the next clock edge, for k in 0,1,2,5,6,7,8,10–14,16–26. The bit stays set until a read.
- R3: While `rd_i` is high, `stat_o` shows the word before clearing. The clock edge that ends the read cycle clears every bit.
- R4: An event that arrives in the same cycle as a read is set after that read.
- R5: Bit 15 reads as the OR of bits 16–22. A pulse on `evt_i[15]` alone has no effect.
- R6: When `prio_en_i` is high, any of `evt_i[26:23]` also sets bit 1, and any bit of `tx_qdesc_i` sets bit 7. When `prio_en_i` is low, bits 23–26 latch by themselves, bit 1 is not set by them, and `tx_qdesc_i` is ignored.
- R7: Bit 4 is set only when `rx_idle_i` goes from 0 to 1, and bit 9 only when `tx_idle_i` goes from 0 to 1. Both levels count as idle at reset. Holding a level high does not set the bit again after a read.
- R8: Bit 3 is set by `rx_early_i` at most once between `pkt_start_i` strobes. It is armed after reset. A `pkt_start_i` in the same cycle as `rx_early_i` re-arms first, so the event counts.
- R9: Bits 27–31 always read zero. Pulses on `evt_i` bits 3, 4, 9 and 27–31 have no effect.
- R10: The mask resets to zero and loads `mask_i` when `mask_wr_i` is high. `irq_o` is high exactly when `stat_o & mask` is non-zero.
- R11: `irq_o` falls in the cycle after a read clears the only masked bit that was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Event pulses, one per status bit position |
| tx_qdesc_i | input | NUM_Q | Per-queue transmit descriptor event pulses |
| rx_idle_i | input | 1 | Receive state machine idle level |
| tx_idle_i | input | 1 | Transmit state machine idle level |
| rx_early_i | input | 1 | Receive drain threshold reached pulse |
| pkt_start_i | input | 1 | Start of a received packet |
| prio_en_i | input | 1 | Priority queueing enable |
| rd_i | input | 1 | Host read of the status word (clears it) |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_i | input | 32 | Mask write data |
| stat_o | output | 32 | Status word |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A bit that fails to latch or is lost on a read shows on `stat_o` one cycle after the pulse, or one cycle after the read. The bench samples each word at that cycle. A stale idle-edge or early-threshold register shows up as a status bit that is missing or repeated on the next transition, or on the next threshold pulse. Wrong aggregation appears directly in bit 15 or in bits 1 and 7 in the cycle after the queue event. A faulty mask register is visible on `irq_o` within one cycle of the write.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned NUM_Q    = 4;
  localparam int unsigned B_RXDESC = 1;
  localparam int unsigned B_EARLY  = 3;
  localparam int unsigned B_RXIDLE = 4;
  localparam int unsigned B_TXDESC = 7;
  localparam int unsigned B_TXIDLE = 9;
  localparam int unsigned B_SUM    = 15;
  localparam int unsigned B_SUM_LO = 16;
  localparam int unsigned B_SUM_HI = 22;
  localparam int unsigned B_RXQ_LO = 23;
  localparam int unsigned B_RSV_LO = 27;

  // bits taken straight from evt_i
  function automatic logic [STAT_W-1:0] direct_mask();
    logic [STAT_W-1:0] m;
    for (int i = 0; i < int'(STAT_W); i++)
      m[i] = (i < int'(B_RSV_LO)) && (i != int'(B_EARLY)) && (i != int'(B_RXIDLE))
             && (i != int'(B_TXIDLE)) && (i != int'(B_SUM));
    return m;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_LVL;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;

  // R7
  no_double_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/irq_early_gate.sv
module irq_early_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hit_i,
  output logic fire_o
);
  logic armed_q;

  // a start in the same cycle re-arms before the hit is judged
  assign fire_o = hit_i & (armed_q | start_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      armed_q <= 1'b1;
    else if (fire_o)  armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;

  // R8
  once_per_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (!fire_o || start_i));
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (clr_i ? '0 : stat_q) | set_i;

  assign stat_o = stat_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R3
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> stat_q == '0);
  // R4
  no_lost_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((stat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
#(
  parameter int unsigned NUM_Q = irq_pkg::NUM_Q
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       evt_i,
  input  logic [NUM_Q-1:0]  tx_qdesc_i,
  input  logic              rx_idle_i,
  input  logic              tx_idle_i,
  input  logic              rx_early_i,
  input  logic              pkt_start_i,
  input  logic              prio_en_i,
  input  logic              rd_i,
  input  logic              mask_wr_i,
  input  logic [31:0]       mask_i,
  output logic [31:0]       stat_o,
  output logic              irq_o
);
  localparam logic [STAT_W-1:0] DIRECT = direct_mask();

  logic              rx_rise, tx_rise, early_fire;
  logic [STAT_W-1:0] set_v, held, mask_q;

  irq_edge_det #(.RST_LVL(1'b1)) i_rx_edge (
    .clk_i, .rst_ni, .lvl_i(rx_idle_i), .rise_o(rx_rise));
  irq_edge_det #(.RST_LVL(1'b1)) i_tx_edge (
    .clk_i, .rst_ni, .lvl_i(tx_idle_i), .rise_o(tx_rise));

  irq_early_gate i_early (
    .clk_i, .rst_ni, .start_i(pkt_start_i), .hit_i(rx_early_i), .fire_o(early_fire));

  always_comb begin
    set_v           = evt_i & DIRECT;
    set_v[B_EARLY]  = early_fire;
    set_v[B_RXIDLE] = rx_rise;
    set_v[B_TXIDLE] = tx_rise;
    set_v[B_RXDESC] = evt_i[B_RXDESC] | (prio_en_i & (|evt_i[B_RXQ_LO +: NUM_Q]));
    set_v[B_TXDESC] = evt_i[B_TXDESC] | (prio_en_i & (|tx_qdesc_i));
  end

  irq_sticky_bank #(.W(STAT_W)) i_bank (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(rd_i), .stat_o(held));

  // summary bit is derived from the error group, never stored
  always_comb begin
    stat_o        = held;
    stat_o[B_SUM] = |held[B_SUM_HI:B_SUM_LO];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_i;

  assign irq_o = |(stat_o & mask_q);

  // R9
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[STAT_W-1:B_RSV_LO] == '0);
  // R10
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  // R11
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set_v == '0) |=> !irq_o);
endmodule

// File: tb/test_irq_status_reg.sv
`timescale 1ns/1ps
module test_irq_status_reg;
  localparam int unsigned NQ = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [31:0]   evt_i = '0;
  logic [NQ-1:0] tx_qdesc_i = '0;
  logic          rx_idle_i = 1'b1;
  logic          tx_idle_i = 1'b1;
  logic          rx_early_i = 1'b0;
  logic          pkt_start_i = 1'b0;
  logic          prio_en_i = 1'b0;
  logic          rd_i = 1'b0;
  logic          mask_wr_i = 1'b0;
  logic [31:0]   mask_i = '0;
  logic [31:0]   stat_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  irq_status_reg #(.NUM_Q(NQ)) i_irq_status_reg (
    .clk_i, .rst_ni, .evt_i, .tx_qdesc_i, .rx_idle_i, .tx_idle_i, .rx_early_i,
    .pkt_start_i, .prio_en_i, .rd_i, .mask_wr_i, .mask_i, .stat_o, .irq_o);

  always #2.5 clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_stat(input string req, input logic [31:0] exp);
    chk(stat_o === exp, req, stat_o, exp);
  endtask

  task automatic pulse(input logic [31:0] v);
    evt_i = v; tick(); evt_i = '0;
  endtask

  task automatic do_read(output logic [31:0] d);
    rd_i = 1'b1; d = stat_o; tick(); rd_i = 1'b0;
  endtask

  task automatic clear();
    logic [31:0] d;
    do_read(d);
  endtask

  task automatic t_reset();
    chk_stat("R1 stat", 32'h0);
    chk(irq_o === 1'b0, "R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    pulse(32'h0000_0001);
    chk_stat("R2 single", 32'h1);
    tick(); tick();
    chk_stat("R2 sticky", 32'h1);
    do_read(d);
    chk(d === 32'h1, "R3 read data", d, 32'h1);
    chk_stat("R3 cleared", 32'h0);
    pulse(32'h0000_1D45);
    chk_stat("R2 pattern", 32'h0000_1D45);
    pulse(32'h0000_0020);
    chk_stat("R2 accumulate", 32'h0000_1D65);
    clear();
    chk_stat("R3 cleared2", 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(32'h1);
    evt_i = 32'h4; rd_i = 1'b1; d = stat_o; tick(); rd_i = 1'b0; evt_i = '0;
    chk(d === 32'h1, "R4 read data", d, 32'h1);
    chk_stat("R4 kept", 32'h4);
    clear();
  endtask

  task automatic t_summary();
    pulse(32'h0004_0000);
    chk_stat("R5 bit18", 32'h0004_8000);
    pulse(32'h0040_0000);
    chk_stat("R5 bit22", 32'h0044_8000);
    clear();
    chk_stat("R5 cleared", 32'h0);
    pulse(32'h0000_8000);
    chk_stat("R5 direct ignored", 32'h0);
  endtask

  task automatic t_prio();
    prio_en_i = 1'b0;
    pulse(32'h0100_0000);
    chk_stat("R6 off rxq", 32'h0100_0000);
    tx_qdesc_i = 4'b0010; tick(); tx_qdesc_i = '0;
    chk_stat("R6 off txq", 32'h0100_0000);
    clear();
    pulse(32'h0000_0002);
    chk_stat("R6 off direct", 32'h2);
    clear();
    prio_en_i = 1'b1;
    pulse(32'h0200_0000);
    chk_stat("R6 on rxq", 32'h0200_0002);
    tx_qdesc_i = 4'b1000; tick(); tx_qdesc_i = '0;
    chk_stat("R6 on txq", 32'h0200_0082);
    clear();
    prio_en_i = 1'b0;
  endtask

  task automatic t_idle();
    rx_idle_i = 1'b0; tick();
    chk_stat("R7 rx leave", 32'h0);
    rx_idle_i = 1'b1; tick();
    chk_stat("R7 rx enter", 32'h10);
    clear(); tick(); tick();
    chk_stat("R7 rx hold", 32'h0);
    tx_idle_i = 1'b0; tick(); tick();
    chk_stat("R7 tx leave", 32'h0);
    tx_idle_i = 1'b1; tick();
    chk_stat("R7 tx enter", 32'h200);
    clear(); tick();
    chk_stat("R7 tx hold", 32'h0);
  endtask

  task automatic t_early();
    rx_early_i = 1'b1; tick(); rx_early_i = 1'b0;
    chk_stat("R8 first", 32'h8);
    clear();
    rx_early_i = 1'b1; tick(); rx_early_i = 1'b0;
    chk_stat("R8 repeat blocked", 32'h0);
    pkt_start_i = 1'b1; tick(); pkt_start_i = 1'b0;
    rx_early_i = 1'b1; tick(); rx_early_i = 1'b0;
    chk_stat("R8 rearmed", 32'h8);
    clear();
    pkt_start_i = 1'b1; rx_early_i = 1'b1; tick(); pkt_start_i = 1'b0; rx_early_i = 1'b0;
    chk_stat("R8 same cycle", 32'h8);
    clear();
    rx_early_i = 1'b1; tick(); rx_early_i = 1'b0;
    chk_stat("R8 blocked after same", 32'h0);
  endtask

  task automatic t_reserved();
    pulse(32'hF800_0218);
    chk_stat("R9 ignored bits", 32'h0);
  endtask

  task automatic t_mask();
    pulse(32'h20);
    chk(irq_o === 1'b0, "R10 mask reset", {31'h0, irq_o}, 32'h0);
    mask_i = 32'h20; mask_wr_i = 1'b1; tick(); mask_wr_i = 1'b0;
    chk(irq_o === 1'b1, "R10 masked on", {31'h0, irq_o}, 32'h1);
    clear();
    chk(irq_o === 1'b0, "R11 irq drop", {31'h0, irq_o}, 32'h0);
    mask_i = 32'h4; mask_wr_i = 1'b1; tick(); mask_wr_i = 1'b0;
    pulse(32'h20);
    chk(irq_o === 1'b0, "R10 other bit", {31'h0, irq_o}, 32'h0);
    clear();
    mask_i = 32'h8000; mask_wr_i = 1'b1; tick(); mask_wr_i = 1'b0;
    pulse(32'h0010_0000);
    chk(irq_o === 1'b1, "R10 summary mask", {31'h0, irq_o}, 32'h1);
    clear();
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_direct();
    t_race();
    t_summary();
    t_prio();
    t_idle();
    t_early();
    t_reserved();
    t_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule